// File: doc/BRIEF.md
# Four-Plane Latched Copy Unit

This block sits between a CPU bus and a video memory made of four byte-wide bitplanes. All four planes answer at the same CPU address range. Each CPU request reaches every plane at once, and the block decides from two mode inputs what that request does. One input covers reads and the other covers writes.

In normal mode the block works as a plain memory port. A read returns the byte held by the plane named by a read-plane select. A write stores the CPU byte in every plane whose bit is set in a plane write mask.

In latched mode the CPU data has no meaning. A read copies the addressed byte of all four planes into four internal latches, one per plane. A later write stores each latch byte back into its own plane at the new address. One read followed by one write therefore moves four planes' worth of pixels. That is 8 pixels with a 4-bit-per-pixel planar layout, or 32 pixels with a 1-bit layout. The latches keep their value until the next latched read, so a single read can feed many writes.

Top module: `plane_latch_copy`

## Requirements
- R1: While reset is high and in the first cycle after it, `cpu_ready` is 0 and `cpu_rdata` is 0x00.
- R2: A request is taken when `cpu_req` is 1 and `cpu_ready` is 0. `cpu_ready` is 1 for exactly the one cycle after a taken request, and is never 1 in two consecutive cycles.
- R3: A normal read (`rd_latched`=0) returns, in its ready cycle, the byte that plane `rd_plane` holds at `cpu_addr`. The encoding is 0 to 3 for planes 0 to 3.
- R4: A normal write (`wr_latched`=0) stores `cpu_wdata` at `cpu_addr` in every plane p whose bit p of `wr_mask` is 1. Planes whose mask bit is 0 keep their contents.
- R5: A latched read loads every plane's byte at `cpu_addr` into that plane's latch. The byte returned in its ready cycle is 0x00.
- R6: A latched write stores latch p into plane p at `cpu_addr` for all four planes. Both `cpu_wdata` and `wr_mask` are ignored.
- R7: The latches change only on a latched read. Normal reads and all writes leave them unchanged, so repeated latched writes store the same bytes.
- R8: The read mode and the write mode act independently. With reads latched and writes normal, writes still store `cpu_wdata` under the mask.
- R9: A request presented during a `cpu_ready` cycle is not taken, and it touches no plane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Byte address, common to all planes |
| cpu_wdata | input | 8 | Write byte (normal write mode only) |
| cpu_rdata | output | 8 | Read byte, valid in the ready cycle |
| cpu_ready | output | 1 | Access complete, one cycle after the request is taken |
| rd_latched | input | 1 | Read mode: 1 = load latches, 0 = normal |
| wr_latched | input | 1 | Write mode: 1 = store latches, 0 = normal |
| rd_plane | input | 2 | Plane returned by normal reads |
| wr_mask | input | 4 | Planes written by normal writes, bit p = plane p |

## Verification
The assertions check the handshake timing on every cycle: ready is idle after reset, appears one cycle after a taken request, and is never held for two cycles. They also check that latched reads always return zero and that the latch bank holds its value on every cycle without a latched read. Where bytes land in the planes can only be shown by the bench's scenarios. These cover masked writes, latch copies to several addresses, mode independence and ignored requests, and the bench reads the planes back through normal reads and compares against a scoreboard.

// File: rtl/plc_pkg.sv
package plc_pkg;

    localparam int PLANES = 4;
    localparam int DW     = 8;
    localparam int SELW   = $clog2(PLANES);

    typedef logic [DW-1:0] pbyte_t;
    typedef logic [PLANES-1:0] pmask_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_RNORM = 2'd1,
        OP_RLAT  = 2'd2,
        OP_WRITE = 2'd3
    } op_e;

    // Registered record of the access that completes in the ready cycle
    typedef struct packed {
        op_e             op;
        logic [SELW-1:0] sel;
    } pend_t;

    function automatic pmask_t write_enables(logic latched, pmask_t mask);
        return latched ? {PLANES{1'b1}} : mask;
    endfunction

endpackage

// File: rtl/plc_ctrl.sv
module plc_ctrl
    import plc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cpu_req,
    input  logic            cpu_we,
    input  logic            rd_latched,
    input  logic            wr_latched,
    input  logic [SELW-1:0] rd_plane,
    input  pmask_t          wr_mask,
    output logic            rd_en,
    output logic            ld_latch,
    output pmask_t          pl_we,
    output logic            wsel_latch,
    output logic            cpu_ready,
    output pend_t           pend
);

    logic take;

    assign take       = cpu_req && !cpu_ready;
    assign rd_en      = take && !cpu_we;
    assign ld_latch   = rd_en && rd_latched;
    assign pl_we      = (take && cpu_we) ? write_enables(wr_latched, wr_mask) : '0;
    assign wsel_latch = wr_latched;

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_ready <= 1'b0;
            pend      <= '{op: OP_IDLE, sel: '0};
        end else begin
            cpu_ready <= take;
            if (take) begin
                pend.sel <= rd_plane;
                if (cpu_we)          pend.op <= OP_WRITE;
                else if (rd_latched) pend.op <= OP_RLAT;
                else                 pend.op <= OP_RNORM;
            end else begin
                pend.op <= OP_IDLE;
            end
        end
    end

endmodule

// File: rtl/plc_plane.sv
module plc_plane
    import plc_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          rd_en,
    input  logic          ld_latch,
    input  logic          we,
    input  logic          wsel_latch,
    input  pbyte_t        cpu_wdata,
    output pbyte_t        dout,
    output pbyte_t        latch
);

    localparam int DEPTH = 1 << AW;

    pbyte_t mem [DEPTH];
    pbyte_t wbyte;

    assign wbyte = wsel_latch ? latch : cpu_wdata;

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wbyte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout  <= '0;
            latch <= '0;
        end else if (rd_en) begin
            dout <= mem[addr];
            if (ld_latch) latch <= mem[addr];
        end
    end

endmodule

// File: rtl/plc_rdmux.sv
module plc_rdmux
    import plc_pkg::*;
(
    input  logic                     cpu_ready,
    input  pend_t                    pend,
    input  logic [PLANES-1:0][DW-1:0] douts,
    output pbyte_t                   cpu_rdata
);

    always_comb begin
        cpu_rdata = '0;
        if (cpu_ready && pend.op == OP_RNORM) cpu_rdata = douts[pend.sel];
    end

endmodule

// File: rtl/plane_latch_copy.sv
module plane_latch_copy
    import plc_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [7:0]    cpu_wdata,
    output logic [7:0]    cpu_rdata,
    output logic          cpu_ready,
    input  logic          rd_latched,
    input  logic          wr_latched,
    input  logic [1:0]    rd_plane,
    input  logic [3:0]    wr_mask
);

    logic                      rd_en;
    logic                      ld_latch;
    logic                      wsel_latch;
    pmask_t                    pl_we;
    pend_t                     pend;
    logic [PLANES-1:0][DW-1:0] douts;
    logic [PLANES-1:0][DW-1:0] latch_bus;

    plc_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .rd_latched (rd_latched),
        .wr_latched (wr_latched),
        .rd_plane   (rd_plane),
        .wr_mask    (wr_mask),
        .rd_en      (rd_en),
        .ld_latch   (ld_latch),
        .pl_we      (pl_we),
        .wsel_latch (wsel_latch),
        .cpu_ready  (cpu_ready),
        .pend       (pend)
    );

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        plc_plane #(.AW(AW)) u_plane (
            .clk        (clk),
            .rst        (rst),
            .addr       (cpu_addr),
            .rd_en      (rd_en),
            .ld_latch   (ld_latch),
            .we         (pl_we[p]),
            .wsel_latch (wsel_latch),
            .cpu_wdata  (cpu_wdata),
            .dout       (douts[p]),
            .latch      (latch_bus[p])
        );
    end

    plc_rdmux u_rdmux (
        .cpu_ready (cpu_ready),
        .pend      (pend),
        .douts     (douts),
        .cpu_rdata (cpu_rdata)
    );

endmodule

// File: rtl/plane_latch_copy_chk.sv
module plane_latch_copy_chk (
    input logic        clk,
    input logic        rst,
    input logic        cpu_req,
    input logic        cpu_we,
    input logic        cpu_ready,
    input logic [7:0]  cpu_rdata,
    input logic        rd_latched,
    input logic        ld_latch,
    input logic [31:0] latch_bus
);

    // R1
    after_reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!cpu_ready && cpu_rdata == 8'h00));

    // R2
    ready_follows_take_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_ready) |=> cpu_ready);

    // R2
    ready_single_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    // R5
    latched_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && $past(!cpu_we && rd_latched)) |-> cpu_rdata == 8'h00);

    // R7
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ld_latch |=> $stable(latch_bus));

endmodule

bind plane_latch_copy plane_latch_copy_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_ready  (cpu_ready),
    .cpu_rdata  (cpu_rdata),
    .rd_latched (rd_latched),
    .ld_latch   (ld_latch),
    .latch_bus  (latch_bus)
);

// File: tb/plane_latch_copy_test.sv
module plane_latch_copy_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_req = 1'b0;
    logic       cpu_we = 1'b0;
    logic [7:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       cpu_ready;
    logic       rd_latched = 1'b0;
    logic       wr_latched = 1'b0;
    logic [1:0] rd_plane = '0;
    logic [3:0] wr_mask = '0;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic       is_read;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb[$];

    always #5 clk = ~clk;

    plane_latch_copy #(.AW(8)) uut (
        .clk        (clk),
        .rst        (rst),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .cpu_ready  (cpu_ready),
        .rd_latched (rd_latched),
        .wr_latched (wr_latched),
        .rd_plane   (rd_plane),
        .wr_mask    (wr_mask)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Monitor: every ready cycle pops one scoreboard item
    always @(negedge clk) begin
        if (!rst && cpu_ready) begin
            if (sb.size() == 0) begin
                check("R2 unexpected ready", 8'h01, 8'h00);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (it.is_read) check(it.tag, cpu_rdata, it.exp);
            end
        end
    end

    task automatic access(logic we, logic [7:0] a, logic [7:0] wd,
                          logic [7:0] exp, string tag);
        item_t it;
        it.is_read = !we;
        it.exp     = exp;
        it.tag     = tag;
        sb.push_back(it);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_norm(logic [1:0] p, logic [7:0] a, logic [7:0] exp, string tag);
        rd_latched = 1'b0; rd_plane = p;
        access(1'b0, a, 8'h00, exp, tag);
    endtask

    task automatic wr_norm(logic [3:0] m, logic [7:0] a, logic [7:0] d);
        wr_latched = 1'b0; wr_mask = m;
        access(1'b1, a, d, 8'h00, "wr");
    endtask

    initial begin
        #200000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 ready in reset", {7'b0, cpu_ready}, 8'h00);
        check("R1 rdata in reset", cpu_rdata, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready after reset", {7'b0, cpu_ready}, 8'h00);

        // R4 broadcast and per-plane masked writes
        wr_norm(4'b1111, 8'd5, 8'hA5);
        for (int p = 0; p < 4; p++) wr_norm(4'(1 << p), 8'd10, 8'(8'h10 + p));
        // R3 per-plane reads
        for (int p = 0; p < 4; p++) rd_norm(2'(p), 8'd10, 8'(8'h10 + p), "R3 plane read");
        wr_norm(4'b0101, 8'd5, 8'h3C);
        rd_norm(2'd0, 8'd5, 8'h3C, "R4 mask set p0");
        rd_norm(2'd1, 8'd5, 8'hA5, "R4 mask clear p1");
        rd_norm(2'd2, 8'd5, 8'h3C, "R4 mask set p2");
        rd_norm(2'd3, 8'd5, 8'hA5, "R4 mask clear p3");

        // R5 latched read from address 10
        rd_latched = 1'b1; rd_plane = 2'd2;
        access(1'b0, 8'd10, 8'h00, 8'h00, "R5 latched rdata zero");

        // R6 latched writes, data and mask ignored
        wr_latched = 1'b1; wr_mask = 4'b0000;
        access(1'b1, 8'd20, 8'hFF, 8'h00, "wr");
        access(1'b1, 8'd21, 8'hEE, 8'h00, "wr");
        // R7 a normal read in between leaves the latches alone
        rd_norm(2'd0, 8'd5, 8'h3C, "R7 normal read between");
        wr_latched = 1'b1;
        access(1'b1, 8'd22, 8'h00, 8'h00, "wr");
        for (int p = 0; p < 4; p++) begin
            rd_norm(2'(p), 8'd20, 8'(8'h10 + p), "R6 latch copy addr20");
            rd_norm(2'(p), 8'd21, 8'(8'h10 + p), "R7 repeat copy addr21");
            rd_norm(2'(p), 8'd22, 8'(8'h10 + p), "R7 copy after normal read");
        end

        // R8 reads latched, writes normal
        rd_latched = 1'b1;
        wr_latched = 1'b0; wr_mask = 4'b1010;
        access(1'b1, 8'd20, 8'h77, 8'h00, "wr");
        rd_norm(2'd1, 8'd20, 8'h77, "R8 normal write p1");
        rd_norm(2'd0, 8'd20, 8'h10, "R8 unmasked p0");

        // R9 request during the ready cycle is not taken
        wr_norm(4'b1111, 8'd41, 8'h55);
        sb.push_back('{is_read: 1'b0, exp: 8'h00, tag: "wr"});
        @(negedge clk);
        wr_latched = 1'b0; wr_mask = 4'b1111;
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'd40; cpu_wdata = 8'h11;
        @(negedge clk);
        cpu_addr = 8'd41; cpu_wdata = 8'h22;
        @(negedge clk);
        cpu_req = 1'b0;
        @(negedge clk);
        rd_norm(2'd3, 8'd41, 8'h55, "R9 ignored request p3");
        rd_norm(2'd0, 8'd40, 8'h11, "R9 first request stored");
        check("R2 scoreboard drained", 8'(sb.size()), 8'h00);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule